// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

This block is one logic cell of a sum-of-products programmable array. A wide configuration vector takes the place of programmed fuses. Five local AND terms are built from a 52-bit literal pool: 36 routed signals and 16 shared expander terms. Each term can pick the true or the inverted form of any literal. The configuration steers each term into a sum path or gives it a secondary job on the output register. The sum path is an OR followed by an XOR polarity stage. The secondary jobs are clock enable, clear, preset, clock, and the second data input.

The cell also exchanges terms with its neighbours. It exports one of its terms, inverted, as a shareable expander. It can lend terms to the next cell and take in terms lent by the previous one. The output register works as a D, T, JK or SR flip-flop, or the register can be bypassed. Its clock comes from either of two global clocks or from a product term. All pins are plain level signals with no handshake. Configuration should change only while the selected clock is idle.

Top module: `mc_macrocell`

## Requirements
- R1: A product term is the AND of every literal whose true-select bit is set and the complement of every literal whose complement-select bit is set. A term that selects both forms of one literal is 0. A term that selects nothing is 1.
- R2: Literal index 0..35 is `route_in`, and literal index 36..51 is `share_in` bit 0..15.
- R3: A term feeds the OR only when its sum bit is set, its lend bit is clear and its secondary role is off. The secondary roles are: term 0 is clock enable, term 1 is clear, term 2 is preset, term 3 is clock (clock select 2 or 3), and term 4 is the second data input (JK or SR mode, or XOR operand).
- R4: `share_out` is the inverse of the term picked by the 3-bit share selector. Selector values 5..7 give 1.
- R5: `par_out` is the OR of lent terms that have no secondary role, ORed with `par_in` when pass-through is set. `par_in` joins the local OR when take-in is set.
- R6: The register kind is encoded as D=0, T=1, JK=2, SR=3. Data input A is the combinational result (or the pin) and B is term 4. T toggles on A. JK: 11 toggles, 10 sets, 01 clears, 00 holds. SR: 10 sets, 01 clears, 11 and 00 hold.
- R7: Clear and preset act at once, without a clock edge. Clear forces 0 and comes from `gclr_n` low (when the global-clear enable is set) or from term 1. Preset forces 1 and comes from term 2. Clear wins when both are active.
- R8: With the enable role on, a clock edge while term 0 is 0 leaves the register unchanged.
- R9: Clock select 0 uses `gclk[0]`, 1 uses `gclk[1]`, and 2 or 3 uses the rising edge of term 3.
- R10: The combinational result is the OR sum XORed with term 4 (XOR-term bit set) or with the invert bit.
- R11: Bypass drives `mc_out` from the combinational result, otherwise from the register. Fast select loads A from `pin_in` instead of the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| route_in | input | 36 | Routed literals |
| share_in | input | 16 | Shared expander literals |
| par_in | input | 1 | Terms lent by previous cell |
| gclk | input | 2 | Global clocks |
| gclr_n | input | 1 | Global clear, active low |
| pin_in | input | 1 | Fast pin input |
| cfg_bits | input | 547 | Packed configuration vector (`mc_cfg_t`) |
| mc_out | output | 1 | Cell output |
| share_out | output | 1 | Inverted shareable term |
| par_out | output | 1 | Terms lent to next cell |

## Verification
The hardest state to reach from the ports is the register's mode table for every starting value: each kind must be seen with Q at 0 and at 1 under all four A/B pairs. The bench reaches a chosen Q with no clock at all. A clear pulse gives 0, and a product-term preset gives 1 when a routed literal is raised. It then drives A from the pin and B from a term on one routed signal, and gives a single global clock edge. A term-derived clock is produced by configuring term 3 on one literal and raising that literal.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int ROUTE_W = 36;
  localparam int SHARE_W = 16;
  localparam int NTERM   = 5;
  localparam int LIT_W   = ROUTE_W + SHARE_W;
  localparam int SEL_W   = $clog2(NTERM + 1);

  // secondary role of each term index
  localparam int PT_CE  = 0;
  localparam int PT_CLR = 1;
  localparam int PT_PRE = 2;
  localparam int PT_CLK = 3;
  localparam int PT_AUX = 4;

  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_kind_e;

  typedef struct packed {
    logic [NTERM-1:0][LIT_W-1:0] lit_pos;
    logic [NTERM-1:0][LIT_W-1:0] lit_neg;
    logic [NTERM-1:0]            sum_en;
    logic [NTERM-1:0]            lend;
    logic                        par_take;
    logic                        chain_thru;
    logic                        xor_pt;
    logic                        xor_inv;
    logic [SEL_W-1:0]            shr_sel;
    logic                        ce_en;
    logic                        clr_pt_en;
    logic                        pre_pt_en;
    logic                        gclr_en;
    logic [1:0]                  clk_src;
    ff_kind_e                    kind;
    logic                        bypass;
    logic                        fast_sel;
  } mc_cfg_t;

  localparam int CFG_W = $bits(mc_cfg_t);
endpackage

// File: rtl/mc_pterm_array.sv
module mc_pterm_array #(
  parameter int LW = 52,
  parameter int NT = 5
) (
  input  logic [LW-1:0]         lit,
  input  logic [NT-1:0][LW-1:0] pos,
  input  logic [NT-1:0][LW-1:0] neg,
  output logic [NT-1:0]         pt
);
  for (genvar t = 0; t < NT; t++) begin : g_term
    // an unselected literal contributes 1 to the AND
    assign pt[t] = &((lit | ~pos[t]) & (~lit | ~neg[t]));
  end
endmodule

// File: rtl/mc_steer.sv
module mc_steer
  import mc_pkg::*;
#(
  parameter int NT = NTERM,
  parameter int SW = SEL_W
) (
  input  logic [NT-1:0] pt,
  input  logic          par_in,
  input  logic          gclr_n,
  input  logic [NT-1:0] sum_en,
  input  logic [NT-1:0] lend,
  input  logic          par_take,
  input  logic          chain_thru,
  input  logic          xor_pt,
  input  logic          xor_inv,
  input  logic [SW-1:0] shr_sel,
  input  logic          ce_en,
  input  logic          clr_pt_en,
  input  logic          pre_pt_en,
  input  logic          gclr_en,
  input  logic          clk_from_pt,
  input  ff_kind_e      kind,
  output logic          comb,
  output logic          par_out,
  output logic          share_out,
  output logic          ce,
  output logic          clr_n,
  output logic          pre_n,
  output logic          pt_clk,
  output logic          aux
);
  logic [NT-1:0] sec_on;
  logic [NT-1:0] in_sum;
  logic          or_sum;

  always_comb begin
    sec_on         = '0;
    sec_on[PT_CE]  = ce_en;
    sec_on[PT_CLR] = clr_pt_en;
    sec_on[PT_PRE] = pre_pt_en;
    sec_on[PT_CLK] = clk_from_pt;
    sec_on[PT_AUX] = (kind == FF_JK) || (kind == FF_SR) || xor_pt;
  end

  assign in_sum  = sum_en & ~lend & ~sec_on;
  assign or_sum  = (|(pt & in_sum)) | (par_take & par_in);
  assign comb    = or_sum ^ (xor_pt ? pt[PT_AUX] : xor_inv);
  assign par_out = (|(pt & lend & ~sec_on)) | (chain_thru & par_in);

  always_comb begin
    share_out = 1'b1;
    for (int t = 0; t < NT; t++)
      if (shr_sel == t[SW-1:0]) share_out = ~pt[t];
  end

  assign ce     = ce_en ? pt[PT_CE] : 1'b1;
  assign clr_n  = ~((gclr_en & ~gclr_n) | (clr_pt_en & pt[PT_CLR]));
  assign pre_n  = ~(pre_pt_en & pt[PT_PRE]);
  assign pt_clk = pt[PT_CLK];
  assign aux    = pt[PT_AUX];
endmodule

// File: rtl/mc_reg.sv
module mc_reg
  import mc_pkg::*;
(
  input  logic [1:0] gclk,
  input  logic [1:0] clk_src,
  input  logic       pt_clk,
  input  logic       clr_n,
  input  logic       pre_n,
  input  logic       ce,
  input  ff_kind_e   kind,
  input  logic       a,
  input  logic       b,
  output logic       q
);
  logic rclk;
  logic nxt;

  assign rclk = clk_src[1] ? pt_clk : (clk_src[0] ? gclk[1] : gclk[0]);

  always_comb begin
    unique case (kind)
      FF_D:  nxt = a;
      FF_T:  nxt = q ^ a;
      FF_JK: nxt = (a & b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
      FF_SR: nxt = (a & ~b) ? 1'b1 : ((~a & b) ? 1'b0 : q);
    endcase
  end

  always_ff @(posedge rclk or negedge clr_n or negedge pre_n) begin
    if (!clr_n)      q <= 1'b0;
    else if (!pre_n) q <= 1'b1;
    else if (ce)     q <= nxt;
  end

  // checker state: low when a clear or preset hit since the last edge
  logic calm;
  always_ff @(posedge rclk or negedge clr_n or negedge pre_n) begin
    if (!clr_n || !pre_n) calm <= 1'b0;
    else                  calm <= 1'b1;
  end

  p_enable_hold_r8: assert property (@(posedge rclk) disable iff (!clr_n || !pre_n)
    !ce |=> (!calm || $stable(q)));
  p_jk_toggle_r6: assert property (@(posedge rclk) disable iff (!clr_n || !pre_n)
    (ce && kind == FF_JK && a && b) |=> (!calm || q != $past(q)));
  p_sr_hold_r6: assert property (@(posedge rclk) disable iff (!clr_n || !pre_n)
    (ce && kind == FF_SR && a && b) |=> (!calm || $stable(q)));
  p_t_toggle_r6: assert property (@(posedge rclk) disable iff (!clr_n || !pre_n)
    (ce && kind == FF_T && a) |=> (!calm || q != $past(q)));
  p_d_follow_r6: assert property (@(posedge rclk) disable iff (!clr_n || !pre_n)
    (ce && kind == FF_D) |=> (!calm || q == $past(a)));
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
(
  input  logic [ROUTE_W-1:0] route_in,
  input  logic [SHARE_W-1:0] share_in,
  input  logic               par_in,
  input  logic [1:0]         gclk,
  input  logic               gclr_n,
  input  logic               pin_in,
  input  logic [CFG_W-1:0]   cfg_bits,
  output logic               mc_out,
  output logic               share_out,
  output logic               par_out
);
  mc_cfg_t          cfg;
  logic [NTERM-1:0] pt;
  logic             comb, ce, clr_n, pre_n, pt_clk, aux, q, data_a;

  assign cfg = mc_cfg_t'(cfg_bits);

  mc_pterm_array #(.LW(LIT_W), .NT(NTERM)) u_terms (
    .lit ({share_in, route_in}),
    .pos (cfg.lit_pos),
    .neg (cfg.lit_neg),
    .pt  (pt)
  );

  mc_steer #(.NT(NTERM), .SW(SEL_W)) u_steer (
    .pt          (pt),
    .par_in      (par_in),
    .gclr_n      (gclr_n),
    .sum_en      (cfg.sum_en),
    .lend        (cfg.lend),
    .par_take    (cfg.par_take),
    .chain_thru  (cfg.chain_thru),
    .xor_pt      (cfg.xor_pt),
    .xor_inv     (cfg.xor_inv),
    .shr_sel     (cfg.shr_sel),
    .ce_en       (cfg.ce_en),
    .clr_pt_en   (cfg.clr_pt_en),
    .pre_pt_en   (cfg.pre_pt_en),
    .gclr_en     (cfg.gclr_en),
    .clk_from_pt (cfg.clk_src[1]),
    .kind        (cfg.kind),
    .comb        (comb),
    .par_out     (par_out),
    .share_out   (share_out),
    .ce          (ce),
    .clr_n       (clr_n),
    .pre_n       (pre_n),
    .pt_clk      (pt_clk),
    .aux         (aux)
  );

  assign data_a = cfg.fast_sel ? pin_in : comb;

  mc_reg u_reg (
    .gclk    (gclk),
    .clk_src (cfg.clk_src),
    .pt_clk  (pt_clk),
    .clr_n   (clr_n),
    .pre_n   (pre_n),
    .ce      (ce),
    .kind    (cfg.kind),
    .a       (data_a),
    .b       (aux),
    .q       (q)
  );

  assign mc_out = cfg.bypass ? comb : q;
endmodule

// File: tb/sim_mc_macrocell.sv
module sim_mc_macrocell;
  import mc_pkg::*;
  localparam int TCK = 10;

  logic [ROUTE_W-1:0] route_in;
  logic [SHARE_W-1:0] share_in;
  logic               par_in, gclr_n, pin_in;
  logic [1:0]         gclk;
  logic [CFG_W-1:0]   cfg_bits;
  logic               mc_out, share_out, par_out;
  mc_cfg_t            c;
  int                 n_run = 0, n_fail = 0;

  assign cfg_bits = c;

  mc_macrocell u0 (.route_in(route_in), .share_in(share_in), .par_in(par_in),
    .gclk(gclk), .gclr_n(gclr_n), .pin_in(pin_in), .cfg_bits(cfg_bits),
    .mc_out(mc_out), .share_out(share_out), .par_out(par_out));

  task automatic chk(string req, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  // every term forced to 0 by selecting both forms of literal 0
  function automatic mc_cfg_t base();
    mc_cfg_t b = '0;
    for (int t = 0; t < NTERM; t++) begin
      b.lit_pos[t][0] = 1'b1;
      b.lit_neg[t][0] = 1'b1;
    end
    b.gclr_en = 1'b1;
    b.kind    = FF_D;
    return b;
  endfunction

  function automatic logic ref_pt(mc_cfg_t k, logic [LIT_W-1:0] l, int t);
    for (int j = 0; j < LIT_W; j++) begin
      if (k.lit_pos[t][j] && !l[j]) return 1'b0;
      if (k.lit_neg[t][j] && l[j])  return 1'b0;
    end
    return 1'b1;
  endfunction

  // returns {comb, share, par}
  function automatic logic [2:0] ref_out(mc_cfg_t k, logic [LIT_W-1:0] l, logic pi);
    logic [NTERM-1:0] p, sec;
    logic s, pr, sh, x;
    for (int t = 0; t < NTERM; t++) p[t] = ref_pt(k, l, t);
    sec = '0;
    sec[PT_CE] = k.ce_en; sec[PT_CLR] = k.clr_pt_en; sec[PT_PRE] = k.pre_pt_en;
    sec[PT_CLK] = k.clk_src[1];
    sec[PT_AUX] = (k.kind == FF_JK) || (k.kind == FF_SR) || k.xor_pt;
    s = k.par_take & pi;
    pr = k.chain_thru & pi;
    for (int t = 0; t < NTERM; t++) begin
      if (k.sum_en[t] && !k.lend[t] && !sec[t]) s = s | p[t];
      if (k.lend[t] && !sec[t]) pr = pr | p[t];
    end
    x  = k.xor_pt ? p[PT_AUX] : k.xor_inv;
    sh = (int'(k.shr_sel) < NTERM) ? ~p[k.shr_sel] : 1'b1;
    return {s ^ x, sh, pr};
  endfunction

  function automatic logic ref_next(ff_kind_e k, logic q, logic a, logic b);
    case (k)
      FF_D:    return a;
      FF_T:    return q ^ a;
      FF_JK:   return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
      default: return (a && !b) ? 1'b1 : ((!a && b) ? 1'b0 : q);
    endcase
  endfunction

  task automatic pulse(int i);
    gclk[i] = 1'b1; #(TCK/2);
    gclk[i] = 1'b0; #(TCK/2);
  endtask

  task automatic do_clear();
    gclr_n = 1'b0; #1; gclr_n = 1'b1; #1;
  endtask

  initial begin : watchdog
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [LIT_W-1:0] l;
    logic [2:0] e;
    c = base(); route_in = '0; share_in = '0; par_in = 0; gclk = '0;
    gclr_n = 0; pin_in = 0;
    #(TCK);
    chk("R7 reset", mc_out, 1'b0);
    gclr_n = 1; #1;

    // R1/R2: one literal per sweep point, both polarities, both values
    for (int j = 0; j < LIT_W; j++)
      for (int pol = 0; pol < 2; pol++)
        for (int v = 0; v < 2; v++) begin
          c = base(); c.lit_pos[0] = '0; c.lit_neg[0] = '0;
          if (pol == 1) c.lit_neg[0][j] = 1'b1; else c.lit_pos[0][j] = 1'b1;
          c.sum_en = 5'b00001; c.bypass = 1; c.shr_sel = 3'd0;
          l = LIT_W'({$urandom(), $urandom()}); l[j] = v[0];
          {share_in, route_in} = l; #1;
          chk(j < ROUTE_W ? "R1 literal" : "R2 shared literal", mc_out, pol[0] ^ v[0]);
          chk("R4 share of term0", share_out, ~(pol[0] ^ v[0]));
        end

    c = base(); c.sum_en = 5'b00001; c.bypass = 1; #1;
    chk("R1 both forms", mc_out, 1'b0);
    c.lit_pos[0] = '0; c.lit_neg[0] = '0; #1;
    chk("R1 empty term", mc_out, 1'b1);
    c.ce_en = 1; #1;
    chk("R3 enable role leaves sum", mc_out, 1'b0);

    c = base();
    for (int t = 0; t < NTERM; t++) begin c.lit_pos[t] = '0; c.lit_neg[t] = '0; end
    c.shr_sel = 3'd5; #1; chk("R4 selector 5", share_out, 1'b1);
    c.shr_sel = 3'd2; #1; chk("R4 selector 2", share_out, 1'b0);

    c = base(); c.bypass = 1; c.lit_pos[1] = '0; c.lit_neg[1] = '0;
    c.lend[1] = 1; c.sum_en[1] = 1; #1;
    chk("R5 lent term not local", mc_out, 1'b0);
    chk("R5 lent term onward", par_out, 1'b1);
    c = base(); c.bypass = 1; par_in = 1; #1;
    chk("R5 no pass-through", par_out, 1'b0);
    c.chain_thru = 1; #1; chk("R5 pass-through", par_out, 1'b1);
    c.par_take = 1; #1; chk("R5 take-in", mc_out, 1'b1);
    par_in = 0;

    c = base(); c.bypass = 1; c.xor_inv = 1; #1;
    chk("R10 invert", mc_out, 1'b1);
    c.xor_inv = 0; c.xor_pt = 1; c.lit_pos[4] = '0; c.lit_neg[4] = '0; c.sum_en[4] = 1; #1;
    chk("R10 term4 operand", mc_out, 1'b1);

    // random configurations, combinational paths
    for (int it = 0; it < 300; it++) begin
      c = base();
      for (int t = 0; t < NTERM; t++)
        for (int j = 0; j < LIT_W; j++) begin
          c.lit_pos[t][j] = ($urandom % 12) == 0;
          c.lit_neg[t][j] = ($urandom % 12) == 0;
        end
      c.sum_en = 5'($urandom); c.lend = 5'($urandom);
      c.par_take = 1'($urandom); c.chain_thru = 1'($urandom);
      c.xor_pt = 1'($urandom); c.xor_inv = 1'($urandom);
      c.shr_sel = 3'($urandom); c.ce_en = 1'($urandom);
      c.kind = ff_kind_e'($urandom % 4); c.bypass = 1;
      l = LIT_W'({$urandom(), $urandom()}); {share_in, route_in} = l;
      par_in = 1'($urandom); #1;
      e = ref_out(c, l, par_in);
      chk("R3 random sum", mc_out, e[2]);
      chk("R4 random share", share_out, e[1]);
      chk("R5 random lend", par_out, e[0]);
    end
    par_in = 0; route_in = '0; share_in = '0;

    // R6: every kind, start value and A/B pair
    for (int k = 0; k < 4; k++)
      for (int q0 = 0; q0 < 2; q0++)
        for (int ab = 0; ab < 4; ab++) begin
          c = base(); c.kind = ff_kind_e'(k); c.fast_sel = 1;
          c.lit_pos[4] = '0; c.lit_neg[4] = '0; c.lit_pos[4][0] = 1;
          c.lit_pos[2] = '0; c.lit_neg[2] = '0; c.lit_pos[2][1] = 1; c.pre_pt_en = 1;
          route_in = '0; pin_in = 0; #1;
          if (q0 == 1) begin route_in[1] = 1; #1; route_in[1] = 0; #1; end
          else do_clear();
          chk("R7 start value", mc_out, q0[0]);
          pin_in = ab[1]; route_in[0] = ab[0]; #1;
          pulse(0);
          chk("R6 register kind", mc_out, ref_next(ff_kind_e'(k), q0[0], ab[1], ab[0]));
        end

    route_in = '0; gclr_n = 0; route_in[1] = 1; #1;
    chk("R7 clear wins", mc_out, 1'b0);
    route_in[1] = 0; gclr_n = 1; #1;

    c = base(); c.fast_sel = 1; c.ce_en = 1;
    c.lit_pos[0] = '0; c.lit_neg[0] = '0; c.lit_pos[0][2] = 1;
    do_clear(); pin_in = 1; route_in[2] = 0; #1; pulse(0);
    chk("R8 enable low holds", mc_out, 1'b0);
    route_in[2] = 1; #1; pulse(0);
    chk("R8 enable high loads", mc_out, 1'b1);
    route_in[2] = 0;

    c = base(); c.fast_sel = 1; c.clk_src = 2'd1;
    do_clear(); pin_in = 1; #1; pulse(0);
    chk("R9 gclk0 ignored", mc_out, 1'b0);
    pulse(1); chk("R9 gclk1 clocks", mc_out, 1'b1);
    c = base(); c.fast_sel = 1; c.clk_src = 2'd2;
    c.lit_pos[3] = '0; c.lit_neg[3] = '0; c.lit_pos[3][3] = 1; #1;
    do_clear(); #1; pulse(0);
    chk("R9 global ignored", mc_out, 1'b0);
    route_in[3] = 1; #(TCK/2); route_in[3] = 0; #(TCK/2);
    chk("R9 term clock", mc_out, 1'b1);

    c = base(); c.lit_pos[0] = '0; c.lit_neg[0] = '0; c.sum_en = 5'b00001;
    do_clear(); pin_in = 0; #1; pulse(0);
    chk("R11 array data", mc_out, 1'b1);
    c.fast_sel = 1; #1; pulse(0);
    chk("R11 pin data", mc_out, 1'b0);
    c.bypass = 1; #1;
    chk("R11 bypass", mc_out, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule